// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This unit performs 32-bit integer multiplication and division for a pipelined integer core. It writes its results into a private pair of result registers, HI and LO, and never into the general register file. The pipeline presents a function code and two source operands, `rs` and `rt`, together with a one-cycle `start` strobe. Multiplies place the 64-bit product across HI (upper half) and LO (lower half). Divides place the quotient in LO and the remainder in HI. The same unit also serves the move-to instructions, which load one register from `rs`, and the move-from instructions, which read one register through a combinational read port.

Multiplication finishes after a fixed four cycles. Division is iterative and resolves one quotient bit per clock. While either operation runs, `busy` stays high. The requesting pipeline must hold back any move-from read until `busy` falls, and the unit discards every `start` it receives while busy. A zero divisor does not trap: it completes with a fixed, defined result.

Top module: `hilo_muldiv_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, HI and LO are cleared to zero and `busy` is cleared to 0.
- R2: Function 24 (signed multiply) forms the full signed 64-bit product of `rs` and `rt`. The low 32 bits go to LO and the high 32 bits go to HI.
- R3: Function 25 (unsigned multiply) forms the unsigned 64-bit product of `rs` and `rt`, with the same low-to-LO and high-to-HI split.
- R4: Function 26 (signed divide) divides `rs` by `rt`. The quotient is truncated toward zero and goes to LO. The remainder takes the sign of the dividend and goes to HI.
- R5: Function 27 (unsigned divide) divides `rs` by `rt`. The quotient goes to LO and the remainder goes to HI.
- R6: Function 17 copies `rs` into HI on the accepting edge, and function 19 copies `rs` into LO on the accepting edge. In both cases the other register keeps its value, and `busy` stays 0.
- R7: `mf_data` shows HI when `funct` is 16 and LO when `funct` is 18. For any other code it shows zero. It does not depend on `start`.
- R8: An accepted multiply raises `busy` for exactly 4 cycles. HI and LO change on the same edge at which `busy` falls.
- R9: An accepted divide raises `busy` for exactly 32 cycles. HI and LO change on the same edge at which `busy` falls.
- R10: A `start` seen while `busy` is high is ignored, whatever its function code. HI and LO keep the values of the running operation.
- R11: A zero divisor completes normally, for both signed and unsigned divide. LO becomes all ones and HI becomes the dividend.
- R12: A signed divide of 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R13: A `start` carrying any function code other than 17, 19 or 24 to 27 changes neither HI, LO nor `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request strobe, sampled when `busy` is low |
| funct | input | 6 | Function code of the request |
| rs | input | 32 | First operand (multiplicand, dividend, move-to value) |
| rt | input | 32 | Second operand (multiplier, divisor) |
| busy | output | 1 | High while a multiply or divide is in flight |
| hi | output | 32 | HI register |
| lo | output | 32 | LO register |
| mf_data | output | 32 | Move-from read data, selected by `funct` |

## Verification
The bench targets the sign handling of the divider:
- Negative dividends and divisors in every sign combination. A divider that fixes up signs wrongly returns a remainder whose sign follows the divisor, or a quotient that is off by one.
- The most-negative-by-minus-one case. A wrong divider returns 0x7FFFFFFF or saturates.
- A zero divisor with a negative dividend. A design that applies the sign correction to the quotient here returns 1 instead of all ones.

It also checks the unit's timing:
- The exact length of `busy`. Any off-by-one in the multiply pipeline or the divide counter shows up as a mismatch in the busy count or as a result that appears a cycle early or late.
- Requests that arrive while busy. A design that lets them through corrupts HI or LO mid-operation.
- Unknown function codes. A design that decodes too loosely writes HI or LO on them.

// File: rtl/mdu_pkg.sv
// Package mdu_pkg
// Shared width and the function codes decoded by the multiply-divide unit.
// Assumes a 6-bit function field taken from the instruction.
package mdu_pkg;
    localparam int unsigned DATA_W = 32;

    localparam logic [5:0] FN_RDHI  = 6'd16;
    localparam logic [5:0] FN_WRHI  = 6'd17;
    localparam logic [5:0] FN_RDLO  = 6'd18;
    localparam logic [5:0] FN_WRLO  = 6'd19;
    localparam logic [5:0] FN_MULS  = 6'd24;
    localparam logic [5:0] FN_MULU  = 6'd25;
    localparam logic [5:0] FN_DIVS  = 6'd26;
    localparam logic [5:0] FN_DIVU  = 6'd27;
endpackage

// File: rtl/mdu_mult.sv
// Module mdu_mult
// Fixed-latency multiplier. It captures the operands on go and reports done
// LAT-1 cycles later. The caller writes the product on the edge at which done
// is seen, which makes the total latency LAT cycles.
// Assumes go is pulsed only while the unit is idle. LAT must be at least 2.
module mdu_mult #(
    parameter int unsigned W   = 32,
    parameter int unsigned LAT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             is_signed,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic             done,
    output logic [2*W-1:0]   product
);
    localparam int unsigned STAGES = LAT - 1;

    logic                         cap_vld;
    logic signed [W:0]            a_q;
    logic signed [W:0]            b_q;
    logic signed [2*W+1:0]        full;
    logic [STAGES-1:0]            vld;
    logic [STAGES-1:0][2*W-1:0]   prod_q;

    // Extended operands: one extra bit turns unsigned into positive signed.
    always_comb full = a_q * b_q;

    // Operand capture register with its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vld <= 1'b0;
        end else begin
            cap_vld <= go;
        end
    end

    // Operand data, no reset needed.
    always_ff @(posedge clk) begin
        if (go) begin
            a_q <= {is_signed & a[W-1], a};
            b_q <= {is_signed & b[W-1], b};
        end
    end

    // Valid flags travel alongside the product stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            vld[0] <= cap_vld;
            for (int k = 1; k < STAGES; k++) vld[k] <= vld[k-1];
        end
    end

    // Product stages: compute once, then delay.
    always_ff @(posedge clk) begin
        prod_q[0] <= full[2*W-1:0];
        for (int k = 1; k < STAGES; k++) prod_q[k] <= prod_q[k-1];
    end

    assign done    = vld[STAGES-1];
    assign product = prod_q[STAGES-1];
endmodule

// File: rtl/mdu_div.sv
// Module mdu_div
// Restoring divider that resolves one quotient bit per clock. It works on
// magnitudes and corrects the signs when it finishes. done is raised together
// with the final quotient and remainder during the W-th stepping cycle.
// Assumes go is pulsed only while idle. A zero divisor yields an all-ones
// quotient and the dividend as remainder.
module mdu_div #(
    parameter int unsigned W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          is_signed,
    input  logic [W-1:0]  dividend,
    input  logic [W-1:0]  divisor,
    output logic          done,
    output logic [W-1:0]  quo,
    output logic [W-1:0]  rem
);
    localparam int unsigned CW   = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic          active;
    logic [CW-1:0] cnt;
    logic [W-1:0]  rem_q, quo_q, dsr_q;
    logic          neg_quo, neg_rem, dsr_zero;
    logic          sgn_a, sgn_b;
    logic [W:0]    shifted, trial;
    logic          fits;
    logic [W-1:0]  rem_n, quo_n;

    // Sign of each operand, only meaningful for a signed divide.
    always_comb begin
        sgn_a = is_signed & dividend[W-1];
        sgn_b = is_signed & divisor[W-1];
    end

    // One restoring step: shift in the next dividend bit, try to subtract.
    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        trial   = shifted - {1'b0, dsr_q};
        fits    = ~trial[W];
        rem_n   = fits ? trial[W-1:0] : shifted[W-1:0];
        quo_n   = {quo_q[W-2:0], fits};
    end

    // Control: start on go, step W times, then go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (go) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            cnt    <= cnt + 1'b1;
            active <= (cnt != LAST);
        end
    end

    // Datapath: load magnitudes on go, otherwise advance one step.
    always_ff @(posedge clk) begin
        if (go) begin
            quo_q    <= sgn_a ? (~dividend + 1'b1) : dividend;
            dsr_q    <= sgn_b ? (~divisor + 1'b1) : divisor;
            rem_q    <= '0;
            dsr_zero <= (divisor == '0);
            neg_quo  <= (sgn_a ^ sgn_b) & (divisor != '0);
            neg_rem  <= sgn_a;
        end else if (active) begin
            quo_q <= quo_n;
            rem_q <= rem_n;
        end
    end

    assign done = active && (cnt == LAST);
    assign quo  = neg_quo ? (~quo_n + 1'b1) : quo_n;
    assign rem  = neg_rem ? (~rem_n + 1'b1) : rem_n;

    // R11: a zero divisor must finish with an all-ones quotient.
    assert_div_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dsr_zero) |-> (quo == '1));
endmodule

// File: rtl/hilo_muldiv_unit.sv
// Module hilo_muldiv_unit
// Owns the HI/LO result pair. It decodes requests into a multiply, a divide
// or a direct write, holds busy while an operation is in flight, and serves
// move-from reads through a combinational port.
// Assumes the requester stalls move-from reads while busy is high. A start
// seen while busy is dropped.
module hilo_muldiv_unit
    import mdu_pkg::*;
#(
    parameter int unsigned W       = DATA_W,
    parameter int unsigned MUL_LAT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [5:0]    funct,
    input  logic [W-1:0]  rs,
    input  logic [W-1:0]  rt,
    output logic          busy,
    output logic [W-1:0]  hi,
    output logic [W-1:0]  lo,
    output logic [W-1:0]  mf_data
);
    localparam int unsigned RUN_W = $clog2(W + 2);

    logic           busy_q;
    logic [W-1:0]   hi_q, lo_q;
    logic           accept;
    logic           is_mul, is_div, is_sgn, is_wrhi, is_wrlo;
    logic           mul_done, div_done;
    logic [2*W-1:0] product;
    logic [W-1:0]   quo, rem;
    logic [RUN_W-1:0] busy_run;

    // Decode of the request; the low bit of the code selects unsigned.
    always_comb begin
        accept  = start && !busy_q;
        is_mul  = (funct == FN_MULS) || (funct == FN_MULU);
        is_div  = (funct == FN_DIVS) || (funct == FN_DIVU);
        is_sgn  = (funct == FN_MULS) || (funct == FN_DIVS);
        is_wrhi = (funct == FN_WRHI);
        is_wrlo = (funct == FN_WRLO);
    end

    mdu_mult #(.W(W), .LAT(MUL_LAT)) u_mult (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (accept && is_mul),
        .is_signed (is_sgn),
        .a         (rs),
        .b         (rt),
        .done      (mul_done),
        .product   (product)
    );

    mdu_div #(.W(W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (accept && is_div),
        .is_signed (is_sgn),
        .dividend  (rs),
        .divisor   (rt),
        .done      (div_done),
        .quo       (quo),
        .rem       (rem)
    );

    // Busy flag: set on an accepted arithmetic request, cleared on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (accept && (is_mul || is_div)) begin
            busy_q <= 1'b1;
        end else if (mul_done || div_done) begin
            busy_q <= 1'b0;
        end
    end

    // HI/LO update: completions first, then direct writes while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (mul_done) begin
            hi_q <= product[2*W-1:W];
            lo_q <= product[W-1:0];
        end else if (div_done) begin
            hi_q <= rem;
            lo_q <= quo;
        end else if (accept && is_wrhi) begin
            hi_q <= rs;
        end else if (accept && is_wrlo) begin
            lo_q <= rs;
        end
    end

    // Move-from read port.
    always_comb begin
        case (funct)
            FN_RDHI: mf_data = hi_q;
            FN_RDLO: mf_data = lo_q;
            default: mf_data = '0;
        endcase
    end

    assign busy = busy_q;
    assign hi   = hi_q;
    assign lo   = lo_q;

    // Checker counter: length of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_run <= '0;
        else if (busy_q) busy_run <= busy_run + 1'b1;
        else             busy_run <= '0;
    end

    // R8: an accepted multiply raises busy on the next cycle.
    assert_mul_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && is_mul) |=> busy);

    // R9: no busy run lasts longer than a full divide.
    assert_busy_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= RUN_W'(W));

    // R6: a write to HI loads rs and leaves LO untouched.
    assert_wrhi_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && is_wrhi) |=> (hi == $past(rs)) && $stable(lo) && !busy);

    // R10: while busy and not finishing, the result pair is frozen.
    assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mul_done && !div_done) |=> $stable(hi) && $stable(lo) && busy);

    // R13: when idle with no valid write request, HI and LO stay unchanged.
    assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(start && (is_wrhi || is_wrlo))) |=> $stable(hi) && $stable(lo));

    // R8/R9: the two engines never finish together.
    assert_one_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mul_done, div_done}));
endmodule

// File: tb/hilo_muldiv_unit_tb.sv
// Bench for hilo_muldiv_unit. A behavioural model updates on each rising edge
// and is compared with the design on every falling edge.
module hilo_muldiv_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  funct = 6'd0;
    logic [31:0] rs = '0, rt = '0;
    logic        busy;
    logic [31:0] hi, lo, mf_data;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit armed = 0;
    string cur_req = "R1";

    // Model state
    logic [31:0] m_hi = '0, m_lo = '0, p_hi, p_lo;
    bit          m_busy = 0;
    int          m_cnt = 0;

    hilo_muldiv_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .funct(funct),
        .rs(rs), .rt(rt), .busy(busy), .hi(hi), .lo(lo), .mf_data(mf_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: arithmetic from the requirements, with latency by countdown.
    always @(posedge clk) begin
        longint sa, sb, sq, sr;
        logic [63:0] up;
        if (!rst_n) begin
            m_hi = '0; m_lo = '0; m_busy = 0; m_cnt = 0;
        end else if (m_busy) begin
            m_cnt--;
            if (m_cnt == 0) begin m_hi = p_hi; m_lo = p_lo; m_busy = 0; end
        end else if (start) begin
            sa = longint'($signed(rs));
            sb = longint'($signed(rt));
            case (funct)
                6'd17: m_hi = rs;
                6'd19: m_lo = rs;
                6'd24: begin up = 64'(sa * sb); p_hi = up[63:32]; p_lo = up[31:0]; m_busy = 1; m_cnt = 4; end
                6'd25: begin up = {32'd0, rs} * {32'd0, rt}; p_hi = up[63:32]; p_lo = up[31:0]; m_busy = 1; m_cnt = 4; end
                6'd26: begin
                    if (rt == 0) begin p_lo = '1; p_hi = rs; end
                    else begin sq = sa / sb; sr = sa % sb; p_lo = sq[31:0]; p_hi = sr[31:0]; end
                    m_busy = 1; m_cnt = 32;
                end
                6'd27: begin
                    if (rt == 0) begin p_lo = '1; p_hi = rs; end
                    else begin p_lo = rs / rt; p_hi = rs % rt; end
                    m_busy = 1; m_cnt = 32;
                end
                default: ;
            endcase
        end
        armed = 1;
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at cycle %0d", cur_req, what, act, exp, cycles);
        end
    endtask

    // Compare every output away from the active edge.
    always @(negedge clk) begin
        logic [31:0] exp_mf;
        cycles++;
        if (armed) begin
            exp_mf = (funct == 6'd16) ? m_hi : (funct == 6'd18) ? m_lo : 32'd0;
            chk("hi", hi, m_hi);
            chk("lo", lo, m_lo);
            chk("busy", {31'd0, busy}, {31'd0, m_busy});
            chk("mf_data R7", mf_data, exp_mf);
        end
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog %s: actual=hang expected=finish", cur_req);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic issue(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk); #1;
        start = 1'b1; funct = f; rs = a; rt = b;
        @(negedge clk); #1;
        start = 1'b0; funct = 6'd0;
    endtask

    task automatic settle();
        do @(negedge clk); while (busy);
        @(negedge clk);
    endtask

    task automatic peek(input logic [5:0] f);
        @(negedge clk); #1;
        funct = f;
        @(negedge clk); #1;
        funct = 6'd0;
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        cur_req = "R6";
        issue(6'd17, 32'hDEAD_BEEF, 32'h0);
        issue(6'd19, 32'h0BAD_F00D, 32'h0);
        cur_req = "R7";
        peek(6'd16);
        peek(6'd18);
        peek(6'd20);

        cur_req = "R2 R8";
        issue(6'd24, 32'h1234_5678, 32'hABCD_EF01); settle();
        issue(6'd24, 32'hFFFF_FFFF, 32'h8000_0000); settle();
        cur_req = "R3 R8";
        issue(6'd25, 32'h1234_5678, 32'hABCD_EF01); settle();
        issue(6'd25, 32'hFFFF_FFFF, 32'hFFFF_FFFF); settle();

        cur_req = "R4 R9";
        issue(6'd26, 32'hABCD_EF01, 32'h1234_5678); settle();
        issue(6'd26, 32'hFFFF_FFF9, 32'h0000_0002); settle();
        issue(6'd26, 32'h0000_0007, 32'hFFFF_FFFE); settle();
        issue(6'd26, 32'hFFFF_FFF9, 32'hFFFF_FFFE); settle();
        cur_req = "R5 R9";
        issue(6'd27, 32'hABCD_EF01, 32'h1234_5678); settle();
        issue(6'd27, 32'h0000_0005, 32'h0000_0009); settle();

        cur_req = "R11";
        issue(6'd26, 32'hF000_0001, 32'h0); settle();
        issue(6'd27, 32'h8765_4321, 32'h0); settle();
        cur_req = "R12";
        issue(6'd26, 32'h8000_0000, 32'hFFFF_FFFF); settle();

        cur_req = "R10";
        issue(6'd27, 32'h7777_7777, 32'h0000_0003);
        issue(6'd17, 32'h1111_1111, 32'h0);
        issue(6'd24, 32'h2222_2222, 32'h3);
        settle();
        issue(6'd24, 32'h0000_0003, 32'h0000_0005);
        issue(6'd19, 32'h5555_5555, 32'h0);
        settle();

        cur_req = "R13";
        issue(6'd16, 32'hAAAA_AAAA, 32'h1);
        issue(6'd28, 32'hAAAA_AAAA, 32'h1);
        issue(6'd0,  32'hAAAA_AAAA, 32'h1);
        peek(6'd16);
        peek(6'd18);

        cur_req = "R1";
        @(negedge clk); #1 rst_n = 1'b0;
        @(negedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule